// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block owns the 16-bit program counter of an 8-bit processor and the 16-bit stack pointer that backs subroutine linkage. On each instruction-complete strobe it chooses the next program counter: the address after the current instruction, a 16-bit target supplied with the instruction, the HL register pair, one of eight fixed restart vectors, or a return address read back from a byte-wide stack in memory.

Jumps, calls and returns can be made conditional on one of the four flags, selected by a 3-bit condition code. Calls and restarts push the return address as two bytes through a memory port addressed by the stack pointer, and returns pop them again. While a push or pop is in progress the block reports busy and ignores further strobes. The stack pointer can also be loaded from HL.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the program counter equals PC_RESET (default 0x0000), the stack pointer equals SP_RESET (default 0x0000), busy is low and no memory access is made while idle.
- R2: A strobe with op 0 or op 7 advances the program counter by the instruction length input `len` (1 to 3), wrapping modulo 2^16, visible one cycle after the strobe.
- R3: A strobe with op 1 (jump) and `cond_en` low loads `imm` into the program counter one cycle after the strobe.
- R4: With `cond_en` high, the flag tested is chosen by cond[2:1] (0 zero, 1 carry, 2 parity, 3 sign) and the transfer is taken when that flag equals cond[0]; this gives codes 0 not-zero, 1 zero, 2 no-carry, 3 carry, 4 parity-odd, 5 parity-even, 6 plus, 7 minus. The parity input is 1 for even parity.
- R5: A conditional jump, call or return that is not taken advances the program counter by `len`, leaves the stack pointer unchanged and makes no memory access.
- R6: A taken call (op 2) writes the high byte of PC+len at SP-1 and then the low byte at SP-2 in two consecutive cycles, after which the program counter equals `imm` and the stack pointer is SP-2.
- R7: A taken return (op 3) reads the low byte at SP and the high byte at SP+1, read data arriving the cycle after each read strobe; the program counter then equals {high, low} and the stack pointer is SP+2.
- R8: A restart (op 4) pushes PC+len as a call does and loads the program counter with `rst_num`*8; it is never conditional.
- R9: Op 5 loads the program counter from `hl` (H high byte, L low byte).
- R10: Op 6 loads the stack pointer from `hl` and advances the program counter by `len`.
- R11: A strobe that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction-complete strobe |
| op | input | 3 | Next-PC operation: 0 sequential, 1 jump, 2 call, 3 return, 4 restart, 5 PC from HL, 6 SP from HL, 7 sequential |
| cond_en | input | 1 | Make jump, call or return conditional |
| cond | input | 3 | Flag condition code |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag, 1 for even |
| flag_s | input | 1 | Sign flag |
| len | input | 2 | Length of the current instruction in bytes |
| imm | input | 16 | Target address carried by the instruction |
| hl | input | 16 | HL register pair |
| rst_num | input | 3 | Restart vector number |
| mem_rdata | input | 8 | Stack read data, valid the cycle after a read strobe |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack write data |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Push or pop in progress |

## Verification
All sixteen condition cases are driven with the untested flags set opposite to the tested one, so a design that decoded the wrong flag or inverted the sense would send the program counter to the wrong place. A call followed by a return checks byte order and stack addresses end to end: swapped bytes or an off-by-one stack address would return to a scrambled address or leave the stack pointer wrong. Untaken conditional calls and returns are checked for silence on the memory port, and a strobe is injected in the middle of a push to catch a design that accepts work while busy. Program counter wraparound past 0xFFFF and the restart vector arithmetic are checked directly.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_RESET = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [2:0]  op,
  input  logic        cond_en,
  input  logic [2:0]  cond,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic        flag_p,
  input  logic        flag_s,
  input  logic [1:0]  len,
  input  logic [15:0] imm,
  input  logic [15:0] hl,
  input  logic [2:0]  rst_num,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        busy
);

  localparam logic [2:0] OP_JUMP = 3'd1, OP_CALL = 3'd2, OP_RET = 3'd3,
                         OP_RST  = 3'd4, OP_PCHL = 3'd5, OP_SPHL = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_PUSH_H, S_PUSH_L, S_POP0, S_POP1, S_POP2} state_t;

  state_t      state;
  logic [15:0] ret_q, tgt_q;
  logic [7:0]  lo_q;
  logic        flag_sel, cond_ok, accept;
  logic [15:0] next_seq;

  assign next_seq = pc + {14'd0, len};
  assign busy     = (state != S_IDLE);
  assign accept   = step && !busy;
  assign cond_ok  = !cond_en || (flag_sel == cond[0]);

  always_comb begin
    case (cond[2:1])
      2'd0:    flag_sel = flag_z;
      2'd1:    flag_sel = flag_c;
      2'd2:    flag_sel = flag_p;
      default: flag_sel = flag_s;
    endcase
  end

  always_comb begin
    mem_addr  = sp;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    case (state)
      S_PUSH_H: begin mem_addr = sp - 16'd1; mem_wdata = ret_q[15:8]; mem_we = 1'b1; end
      S_PUSH_L: begin mem_addr = sp - 16'd2; mem_wdata = ret_q[7:0];  mem_we = 1'b1; end
      S_POP0:   begin mem_addr = sp;         mem_re = 1'b1; end
      S_POP1:   begin mem_addr = sp + 16'd1; mem_re = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= PC_RESET;
      sp    <= SP_RESET;
      ret_q <= 16'h0000;
      tgt_q <= 16'h0000;
      lo_q  <= 8'h00;
    end else begin
      case (state)
        S_IDLE: if (step) begin
          case (op)
            OP_JUMP: pc <= cond_ok ? imm : next_seq;
            OP_CALL: if (cond_ok) begin
                       ret_q <= next_seq;
                       tgt_q <= imm;
                       state <= S_PUSH_H;
                     end else pc <= next_seq;
            OP_RET:  if (cond_ok) state <= S_POP0;
                     else pc <= next_seq;
            OP_RST:  begin
                       ret_q <= next_seq;
                       tgt_q <= {10'd0, rst_num, 3'd0};
                       state <= S_PUSH_H;
                     end
            OP_PCHL: pc <= hl;
            OP_SPHL: begin sp <= hl; pc <= next_seq; end
            default: pc <= next_seq;
          endcase
        end
        S_PUSH_H: state <= S_PUSH_L;
        S_PUSH_L: begin pc <= tgt_q; sp <= sp - 16'd2; state <= S_IDLE; end
        S_POP0:   state <= S_POP1;
        S_POP1:   begin lo_q <= mem_rdata; state <= S_POP2; end
        S_POP2:   begin pc <= {mem_rdata, lo_q}; sp <= sp + 16'd2; state <= S_IDLE; end
        default:  state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re); // R1
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == 3'd0 || op == 3'd7)) |=> pc == $past(pc) + {14'd0, $past(len)}); // R2
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_JUMP && !cond_en) |=> pc == $past(imm)); // R3
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cond_en && !cond_ok && (op == OP_CALL || op == OP_RET)) |=> !busy && sp == $past(sp)); // R5
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> mem_we && mem_addr == $past(mem_addr) - 16'd1); // R6
  AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re) |=> mem_re && mem_addr == $past(mem_addr) + 16'd1); // R7
  AST_PCHL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PCHL) |=> pc == $past(hl)); // R9
  AST_SPHL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SPHL) |=> sp == $past(hl)); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we && !mem_re) |-> $stable(sp)); // R11

endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, cond_en = 1'b0;
  logic [2:0] op = 3'd0, cond = 3'd0, rst_num = 3'd0;
  logic flag_z = 1'b0, flag_c = 1'b0, flag_p = 1'b0, flag_s = 1'b0;
  logic [1:0] len = 2'd1;
  logic [15:0] imm = 16'h0, hl = 16'h0;
  logic [7:0] mem_rdata = 8'h00, mem_wdata;
  logic [15:0] mem_addr, pc, sp;
  logic mem_we, mem_re, busy;

  int checks = 0, errors = 0;
  logic [15:0] exp_pc, exp_sp, ret_a;
  logic [7:0] mem [256];
  logic [15:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  int wr_n = 0, rd_n = 0;

  always #10 clk = ~clk;

  pc_sequencer u_dut (.clk(clk), .rst_n(rst_n), .step(step), .op(op), .cond_en(cond_en),
    .cond(cond), .flag_z(flag_z), .flag_c(flag_c), .flag_p(flag_p), .flag_s(flag_s),
    .len(len), .imm(imm), .hl(hl), .rst_num(rst_num), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pc(pc), .sp(sp), .busy(busy));

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_addr[wr_n[5:0]] <= mem_addr;
      wr_data[wr_n[5:0]] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr[7:0]];
      rd_n <= rd_n + 1;
    end
  end

  // {cond[2:0], s, z, p, c, taken}
  localparam logic [7:0] VEC [16] = '{
    {3'd0, 4'b1011, 1'b1}, {3'd0, 4'b0100, 1'b0},
    {3'd1, 4'b0100, 1'b1}, {3'd1, 4'b1011, 1'b0},
    {3'd2, 4'b1110, 1'b1}, {3'd2, 4'b0001, 1'b0},
    {3'd3, 4'b0001, 1'b1}, {3'd3, 4'b1110, 1'b0},
    {3'd4, 4'b1101, 1'b1}, {3'd4, 4'b0010, 1'b0},
    {3'd5, 4'b0010, 1'b1}, {3'd5, 4'b1101, 1'b0},
    {3'd6, 4'b0111, 1'b1}, {3'd6, 4'b1000, 1'b0},
    {3'd7, 4'b1000, 1'b1}, {3'd7, 4'b0111, 1'b0}};

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic ce, input logic [2:0] c,
                       input logic [15:0] im, input logic [1:0] ln);
    @(negedge clk);
    op = o; cond_en = ce; cond = c; imm = im; len = ln; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(pc == 16'h0000, "R1 pc reset", pc, 16'h0000);
    chk(sp == 16'h0000, "R1 sp reset", sp, 16'h0000);
    chk(!busy && !mem_we && !mem_re, "R1 idle quiet", {busy, mem_we, mem_re}, 16'h0);
    rst_n = 1'b1;
    exp_pc = 16'h0000;

    for (int l = 1; l <= 3; l++) begin
      do_op(3'd0, 1'b0, 3'd0, 16'h0, 2'(l));
      exp_pc = exp_pc + 16'(l);
      chk(pc == exp_pc, "R2 sequential", pc, exp_pc);
    end
    do_op(3'd7, 1'b0, 3'd0, 16'h0, 2'd2);
    exp_pc = exp_pc + 16'd2;
    chk(pc == exp_pc, "R2 op7 sequential", pc, exp_pc);

    do_op(3'd1, 1'b0, 3'd0, 16'h4321, 2'd3);
    chk(pc == 16'h4321, "R3 jump", pc, 16'h4321);

    hl = 16'h0080;
    do_op(3'd6, 1'b0, 3'd0, 16'h0, 2'd1);
    chk(sp == 16'h0080, "R10 sp from hl", sp, 16'h0080);
    chk(pc == 16'h4322, "R10 pc advance", pc, 16'h4322);
    exp_sp = 16'h0080;

    w0 = wr_n; r0 = rd_n;
    exp_pc = 16'h4322;
    for (int i = 0; i < 16; i++) begin
      {flag_s, flag_z, flag_p, flag_c} = VEC[i][4:1];
      do_op(3'd1, 1'b1, VEC[i][7:5], 16'h1000 + 16'(i * 16), 2'd3);
      exp_pc = VEC[i][0] ? 16'h1000 + 16'(i * 16) : exp_pc + 16'd3;
      chk(pc == exp_pc, "R4 condition code", pc, exp_pc);
    end
    chk(wr_n == w0 && rd_n == r0 && sp == exp_sp, "R5 jumps touch no stack", sp, exp_sp);

    hl = 16'h0140;
    do_op(3'd5, 1'b0, 3'd0, 16'h0, 2'd1);
    chk(pc == 16'h0140, "R9 pc from hl", pc, 16'h0140);

    {flag_s, flag_z, flag_p, flag_c} = 4'b1110;
    w0 = wr_n;
    do_op(3'd2, 1'b1, 3'd3, 16'h7777, 2'd3);
    chk(pc == 16'h0143, "R5 untaken call pc", pc, 16'h0143);
    chk(sp == exp_sp && wr_n == w0, "R5 untaken call stack", sp, exp_sp);

    w0 = wr_n;
    do_op(3'd2, 1'b0, 3'd0, 16'h2000, 2'd3);
    ret_a = 16'h0146;
    chk(wr_n == w0 + 2, "R6 two writes", 16'(wr_n - w0), 16'd2);
    chk(wr_addr[w0[5:0]] == 16'h007F && wr_data[w0[5:0]] == ret_a[15:8], "R6 high byte first",
        {wr_addr[w0[5:0]][7:0], wr_data[w0[5:0]]}, {8'h7F, ret_a[15:8]});
    chk(wr_addr[6'(w0 + 1)] == 16'h007E && wr_data[6'(w0 + 1)] == ret_a[7:0], "R6 low byte",
        {wr_addr[6'(w0 + 1)][7:0], wr_data[6'(w0 + 1)]}, {8'h7E, ret_a[7:0]});
    chk(pc == 16'h2000, "R6 call target", pc, 16'h2000);
    chk(sp == 16'h007E, "R6 sp after call", sp, 16'h007E);

    do_op(3'd3, 1'b0, 3'd0, 16'h0, 2'd1);
    chk(pc == ret_a, "R7 return address", pc, ret_a);
    chk(sp == 16'h0080, "R7 sp after return", sp, 16'h0080);

    rst_num = 3'd5;
    w0 = wr_n;
    do_op(3'd4, 1'b1, 3'd0, 16'h0, 2'd1);
    chk(pc == 16'h0028, "R8 restart vector", pc, 16'h0028);
    chk(wr_n == w0 + 2 && wr_data[6'(w0 + 1)] == 8'h47, "R8 push low", {8'h0, wr_data[6'(w0 + 1)]}, 16'h0047);

    flag_z = 1'b0;
    r0 = rd_n;
    do_op(3'd3, 1'b1, 3'd1, 16'h0, 2'd1);
    chk(pc == 16'h0029 && sp == 16'h007E && rd_n == r0, "R5 untaken return", pc, 16'h0029);
    flag_z = 1'b1;
    do_op(3'd3, 1'b1, 3'd1, 16'h0, 2'd1);
    chk(pc == 16'h0147, "R7 conditional return", pc, 16'h0147);

    rst_num = 3'd7;
    @(negedge clk);
    op = 3'd4; cond_en = 1'b0; len = 2'd1; step = 1'b1;
    @(negedge clk);
    op = 3'd1; imm = 16'h5555;
    @(negedge clk);
    step = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(pc == 16'h0038, "R11 strobe while busy ignored", pc, 16'h0038);

    do_op(3'd1, 1'b0, 3'd0, 16'hFFFF, 2'd3);
    do_op(3'd0, 1'b0, 3'd0, 16'h0, 2'd2);
    chk(pc == 16'h0001, "R2 wrap", pc, 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule